// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control unit of a multicycle processor whose datapath shares one memory for instructions and data and one ALU for both address arithmetic and data operations. Every instruction runs as a series of one-cycle steps. The controller is a Moore state machine with ten states. Its only data input is the 6-bit opcode field of the instruction register. From its current state it drives the select lines and write enables that steer the datapath through each step.

A load takes five cycles. A store or a register-to-register ALU operation takes four. A conditional branch or a jump takes three. The path always begins with the shared fetch and decode steps. After decode the machine dispatches on the opcode. An opcode that it does not recognise sends it straight back to fetch, and the discarded instruction writes nothing. The block has no data streams: every pin is a plain control level, so there is no valid/ready handshake and no back-pressure.

Top module: `seq_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset forces the fetch state, so the fetch pattern (R2) appears while reset is held and again in the first cycle after it, even when reset arrives in the middle of an instruction.
- R2: Fetch state asserts pc_wr_en, mem_rd and instr_load. It sets alu_b_sel=01, and mem_addr_from_alu, alu_a_from_reg, alu_mode and pc_src_sel are all 0. The next state is always decode.
- R3: Decode state sets alu_b_sel=11 and leaves everything else 0. It then dispatches on the opcode: 100011 (load) and 101011 (store) go to address computation, 000000 (ALU op) goes to execute, 000100 (branch) goes to branch completion, and 000010 (jump) goes to jump completion.
- R4: Address state sets alu_a_from_reg=1 and alu_b_sel=10 with alu_mode=00. It continues to load-read for opcode 100011 and to store-write otherwise.
- R5: Load-read state asserts mem_rd with mem_addr_from_alu=1 and moves to load write-back. Load write-back asserts rf_wr with rf_wdata_from_mem=1 and rf_dest_rd=0, then returns to fetch.
- R6: Store-write state asserts mem_wr with mem_addr_from_alu=1, then returns to fetch.
- R7: Execute state sets alu_a_from_reg=1, alu_b_sel=00 and alu_mode=10, then moves to ALU write-back. ALU write-back asserts rf_wr with rf_dest_rd=1 and rf_wdata_from_mem=0, then returns to fetch.
- R8: Branch state sets alu_a_from_reg=1, alu_b_sel=00, alu_mode=01, pc_wr_on_zero=1 and pc_src_sel=01, then returns to fetch.
- R9: Jump state asserts pc_wr_en with pc_src_sel=10, then returns to fetch.
- R10: Any other opcode in decode returns the machine to fetch after two cycles, with no register, memory or PC write in between. Instruction lengths from one fetch to the next are 5 for load, 4 for store and ALU op, and 3 for branch and jump.
- R11: Outputs depend only on the state. A change of opcode outside decode and address computation leaves the outputs and the path unchanged.
- R12: Every output that a state does not list is 0. mem_rd and mem_wr are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr_en | output | 1 | Unconditional program counter write |
| pc_wr_on_zero | output | 1 | Program counter write qualified by the ALU zero flag |
| mem_addr_from_alu | output | 1 | Memory address from the ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_load | output | 1 | Instruction register load |
| rf_wdata_from_mem | output | 1 | Register write data from memory data register (0: from ALU result) |
| rf_dest_rd | output | 1 | Destination register from the third register field (0: second field) |
| rf_wr | output | 1 | Register file write enable |
| alu_a_from_reg | output | 1 | ALU first operand from register A (0: from PC) |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 function field decides |
| alu_b_sel | output | 2 | 00 register B, 01 constant 4, 10 sign-extended immediate, 11 immediate shifted left by 2 |
| pc_src_sel | output | 2 | 00 ALU result, 01 ALU result register, 10 jump target |

## Verification
On every cycle the assertions check four things: that fetch always leads to decode, that an unknown opcode in decode leads back to fetch, that each write-back state is entered only from its own predecessor, and that the memory strobes and a store's side effects stay mutually consistent. Only the bench's scenarios can show the full output pattern of each state, the dispatch on every encoding, the instruction lengths, the behaviour of reset in mid-instruction, and the fact that opcode noise outside the dispatching states changes nothing.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
  localparam int ST_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STMEM  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_ALUWB  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } st_e;

  typedef enum logic [2:0] {
    CL_ALU, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_BAD
  } cls_e;

  typedef struct packed {
    logic             pc_wr;
    logic             pc_wr_zero;
    logic             addr_alu;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_ld;
    logic             wb_mem;
    logic             dest_rd;
    logic             rf_wr;
    logic             a_reg;
    logic [SEL_W-1:0] alu_mode;
    logic [SEL_W-1:0] b_sel;
    logic [SEL_W-1:0] pc_src;
  } ctl_t;
endpackage

// File: rtl/seqctl_opclass.sv
module seqctl_opclass
  import seqctl_pkg::*;
#(
  parameter int              OPCODE_W  = 6,
  parameter logic [OPCODE_W-1:0] OP_ALU    = 6'b000000,
  parameter logic [OPCODE_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OPCODE_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OPCODE_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OPCODE_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic [OPCODE_W-1:0] opcode,
  output cls_e                cls
);
  localparam int NCLS = 5;
  localparam logic [NCLS*OPCODE_W-1:0] CODES = {OP_JUMP, OP_BRANCH, OP_STORE, OP_LOAD, OP_ALU};

  logic [NCLS-1:0] hit;

  for (genvar g = 0; g < NCLS; g++) begin : g_match
    assign hit[g] = (opcode == CODES[g*OPCODE_W +: OPCODE_W]);
  end

  always_comb begin
    cls = CL_BAD;
    if (hit[0])      cls = CL_ALU;
    else if (hit[1]) cls = CL_LOAD;
    else if (hit[2]) cls = CL_STORE;
    else if (hit[3]) cls = CL_BRANCH;
    else if (hit[4]) cls = CL_JUMP;
  end
endmodule

// File: rtl/seqctl_next.sv
module seqctl_next
  import seqctl_pkg::*;
(
  input  st_e  cur,
  input  cls_e cls,
  output st_e  nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_ALU:            nxt = ST_EXEC;
          CL_BRANCH:         nxt = ST_BRANCH;
          CL_JUMP:           nxt = ST_JUMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (cls == CL_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_ALUWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/seqctl_outdec.sv
module seqctl_outdec
  import seqctl_pkg::*;
(
  input  st_e  cur,
  output ctl_t ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.b_sel  = 2'b01;
        ctl.pc_wr  = 1'b1;
      end
      ST_DECODE: ctl.b_sel = 2'b11;
      ST_ADDR: begin
        ctl.a_reg = 1'b1;
        ctl.b_sel = 2'b10;
      end
      ST_LDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      ST_EXEC: begin
        ctl.a_reg    = 1'b1;
        ctl.alu_mode = 2'b10;
      end
      ST_ALUWB: begin
        ctl.rf_wr   = 1'b1;
        ctl.dest_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.a_reg      = 1'b1;
        ctl.alu_mode   = 2'b01;
        ctl.pc_wr_zero = 1'b1;
        ctl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = 2'b10;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import seqctl_pkg::*;
#(
  parameter int              OPCODE_W  = 6,
  parameter logic [OPCODE_W-1:0] OP_ALU    = 6'b000000,
  parameter logic [OPCODE_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OPCODE_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OPCODE_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OPCODE_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPCODE_W-1:0] opcode,
  output logic                pc_wr_en,
  output logic                pc_wr_on_zero,
  output logic                mem_addr_from_alu,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                instr_load,
  output logic                rf_wdata_from_mem,
  output logic                rf_dest_rd,
  output logic                rf_wr,
  output logic                alu_a_from_reg,
  output logic [1:0]          alu_mode,
  output logic [1:0]          alu_b_sel,
  output logic [1:0]          pc_src_sel
);
  st_e  state, state_nxt;
  cls_e cls;
  ctl_t ctl;

  seqctl_opclass #(
    .OPCODE_W(OPCODE_W), .OP_ALU(OP_ALU), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_cls (
    .opcode(opcode),
    .cls   (cls)
  );

  seqctl_next u_next (
    .cur(state),
    .cls(cls),
    .nxt(state_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nxt;
  end

  seqctl_outdec u_out (
    .cur(state),
    .ctl(ctl)
  );

  assign pc_wr_en          = ctl.pc_wr;
  assign pc_wr_on_zero     = ctl.pc_wr_zero;
  assign mem_addr_from_alu = ctl.addr_alu;
  assign mem_rd            = ctl.mem_rd;
  assign mem_wr            = ctl.mem_wr;
  assign instr_load        = ctl.ir_ld;
  assign rf_wdata_from_mem = ctl.wb_mem;
  assign rf_dest_rd        = ctl.dest_rd;
  assign rf_wr             = ctl.rf_wr;
  assign alu_a_from_reg    = ctl.a_reg;
  assign alu_mode          = ctl.alu_mode;
  assign alu_b_sel         = ctl.b_sel;
  assign pc_src_sel        = ctl.pc_src;

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  p_bad_back_to_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && cls == CL_BAD) |=> (state == ST_FETCH));

  p_ldwb_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LDWB) |-> ($past(state) == ST_LDMEM));

  p_aluwb_after_exec_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ALUWB) |-> ($past(state) == ST_EXEC));

  p_mem_strobes_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_store_side_effects_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr_from_alu && !rf_wr && !pc_wr_en && !instr_load));
endmodule

// File: tb/seq_ctrl_fsm_tb.sv
module seq_ctrl_fsm_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic       pc_wr_en, pc_wr_on_zero, mem_addr_from_alu, mem_rd, mem_wr;
  logic       instr_load, rf_wdata_from_mem, rf_dest_rd, rf_wr, alu_a_from_reg;
  logic [1:0] alu_mode, alu_b_sel, pc_src_sel;

  int checks = 0;
  int errors = 0;
  int model_st = 0;

  localparam logic [5:0] C_ALU = 6'b000000, C_LD = 6'b100011, C_ST = 6'b101011,
                         C_BR  = 6'b000100, C_J  = 6'b000010;

  always #2 clk = ~clk;

  seq_ctrl_fsm dut_i (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr_en(pc_wr_en), .pc_wr_on_zero(pc_wr_on_zero),
    .mem_addr_from_alu(mem_addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .instr_load(instr_load), .rf_wdata_from_mem(rf_wdata_from_mem),
    .rf_dest_rd(rf_dest_rd), .rf_wr(rf_wr), .alu_a_from_reg(alu_a_from_reg),
    .alu_mode(alu_mode), .alu_b_sel(alu_b_sel), .pc_src_sel(pc_src_sel)
  );

  wire [15:0] obs = {pc_wr_en, pc_wr_on_zero, mem_addr_from_alu, mem_rd, mem_wr,
                     instr_load, rf_wdata_from_mem, rf_dest_rd, rf_wr, alu_a_from_reg,
                     alu_mode, alu_b_sel, pc_src_sel};

  // Field order: pcw pcz addr rd wr ir wbm dst rfw a | mode | bsel | pcsrc
  function automatic logic [15:0] exp_out(int st);
    case (st)
      0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b01,2'b00};
      1: return {10'b0, 2'b00, 2'b11, 2'b00};
      2: return {9'b0, 1'b1, 2'b00, 2'b10, 2'b00};
      3: return {1'b0,1'b0,1'b1,1'b1,6'b0, 6'b0};
      4: return {6'b0,1'b1,1'b0,1'b1,1'b0, 6'b0};
      5: return {1'b0,1'b0,1'b1,1'b0,1'b1,5'b0, 6'b0};
      6: return {9'b0, 1'b1, 2'b10, 2'b00, 2'b00};
      7: return {7'b0,1'b1,1'b1,1'b0, 6'b0};
      8: return {1'b0,1'b1,7'b0,1'b1, 2'b01, 2'b00, 2'b01};
      9: return {1'b1, 9'b0, 2'b00, 2'b00, 2'b10};
      default: return 16'h0;
    endcase
  endfunction

  function automatic int nxt_st(int st, logic [5:0] op);
    case (st)
      0: return 1;
      1: begin
        if (op == C_LD || op == C_ST) return 2;
        if (op == C_ALU) return 6;
        if (op == C_BR)  return 8;
        if (op == C_J)   return 9;
        return 0;
      end
      2: return (op == C_LD) ? 3 : 5;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int path_len(logic [5:0] op);
    if (op == C_LD) return 5;
    if (op == C_ST || op == C_ALU) return 4;
    if (op == C_BR || op == C_J) return 3;
    return 2;
  endfunction

  function automatic string tag(int st);
    case (st)
      0: return "R2 R11 R12";
      1: return "R3 R12";
      2: return "R4 R12";
      3, 4: return "R5 R11 R12";
      5: return "R6 R11 R12";
      6, 7: return "R7 R11 R12";
      8: return "R8 R11 R12";
      9: return "R9 R11 R12";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge: check outputs, drive inputs, advance the model.
  task automatic tick(input logic [5:0] op, input bit r);
    int nx;
    chk(tag(model_st), int'(obs), int'(exp_out(model_st)));
    opcode = op;
    rst    = r;
    nx = r ? 0 : nxt_st(model_st, op);
    @(posedge clk);
    model_st = nx;
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [5:0] op);
    int n = 0;
    do begin
      tick((model_st == 1 || model_st == 2) ? op : 6'($urandom), 1'b0);
      n++;
    end while (obs != exp_out(0) && n < 8);
    chk((path_len(op) == 2) ? "R10" : "R3 R10", n, path_len(op));
  endtask

  initial begin
    rst = 1'b1;
    opcode = 6'h0;
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(obs), int'(exp_out(0)));
    rst = 1'b0;
    model_st = 0;

    // Directed: every class, then unknown encodings (R10)
    run_instr(C_LD);
    run_instr(C_ST);
    run_instr(C_ALU);
    run_instr(C_BR);
    run_instr(C_J);
    run_instr(6'h3F);
    run_instr(6'b000001);
    run_instr(6'b100010);
    run_instr(6'b001011);

    // R1: reset in the middle of a load, at the load-read state
    tick(C_LD, 1'b0);
    tick(C_LD, 1'b0);
    tick(C_LD, 1'b0);
    chk("R1 R5", int'(obs), int'(exp_out(3)));
    tick(C_LD, 1'b1);
    chk("R1", int'(obs), int'(exp_out(0)));
    rst = 1'b0;

    // Constrained random instruction stream
    for (int i = 0; i < 400; i++) begin
      int pick;
      logic [5:0] op;
      pick = int'($urandom % 7);
      case (pick)
        0: op = C_LD;
        1: op = C_ST;
        2: op = C_ALU;
        3: op = C_BR;
        4: op = C_J;
        default: op = 6'($urandom);
      endcase
      run_instr(op);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule